// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external memory bus cycles of a small CPU core. The external bus shares the low address byte with the data byte. The core asks for one of three cycles: an opcode fetch, a memory read or a memory write. With the request it supplies a 16-bit address and, for a write, a data byte. The sequencer then drives these signals:

- the high address byte on dedicated outputs;
- the low byte on a shared lane with its own output enable;
- an address latch strobe;
- active-low read and write strobes.

When the cycle ends it returns the sampled byte and gives a one-tick completion pulse.

The clock input is the oscillator. Every machine state lasts three oscillator ticks. A bus cycle always takes four states, T1 to T4, which is 12 ticks. In the listing below, tick k (0 to 11) counts from the first tick after the request is accepted. State Tn covers ticks 3(n-1) to 3(n-1)+2. Strobe edges sit on single ticks inside a state, not only on state boundaries. T4 carries no bus activity and is left to the core.

The timing points are:

| Event | Ticks (k) |
|---|---|
| Address latch strobe high | 0 |
| Read or fetch: low address on the shared lane | 0–1 |
| Read or fetch: read strobe low | 2–8 |
| Read or fetch: data sampled | end of 8 |
| Write: write strobe low | 1–5 |
| Write: write data on the shared lane | 1–8 |
| Completion pulse | 11 |

Top module: `mux_bus_seq`

## Requirements
- R1: A bus cycle lasts exactly 12 ticks (4 states of 3 ticks). `done` is high only on tick 11 and only for that one tick, and the sequencer is idle on the following tick.
- R2: `addr_hi` equals address bits 15:8 on every tick from 0 to 11. It is zero while idle.
- R3: `ale` is high on tick 0 only. On that tick `ad_oe` is high and `ad_out` carries address bits 7:0. `ale` is never high while `rd_n` or `wr_n` is low.
- R4: For a fetch or read, `ad_oe` is high with address bits 7:0 on ticks 0–1. The lane is released (`ad_oe` low, `ad_out` zero) from tick 2 through tick 11.
- R5: For a fetch or read, `rd_n` is low on ticks 2–8 inclusive and high on all other ticks. `wr_n` stays high.
- R6: For a fetch or read, `ad_in` is captured at the end of tick 8, and `rdata` shows it from tick 9 onward. The `op` encoding is 2'b00 fetch, 2'b01 read, 2'b10 write, and 2'b11 runs as a read. Fetch and read use identical timing.
- R7: For a write, `wr_n` is low on ticks 1–5 inclusive and high on all other ticks. `rd_n` stays high.
- R8: For a write, `ad_oe` is high on ticks 0–8. `ad_out` carries address bits 7:0 on tick 0 and the write data on ticks 1–8. The lane is released on ticks 9–11.
- R9: While idle, `rd_n` and `wr_n` are high, and `ale`, `ad_oe` and `done` are low. `rdata` changes only at a read or fetch sample point, so a write cycle and idle time leave it unchanged.
- R10: A request is taken only while idle. `req` raised during a cycle is ignored: the running cycle's address, data and timing are unchanged.
- R11: Synchronous reset, which may come in the middle of a cycle, returns the block to idle on the next tick. After it `ale` is low, `rd_n` and `wr_n` are high, `ad_oe` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is one tick |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Cycle request, taken when idle |
| op | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write, 11 read |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write data |
| addr_hi | output | 8 | High address byte to memory |
| ad_out | output | 8 | Shared low lane, output value |
| ad_oe | output | 1 | Shared low lane output enable |
| ad_in | input | 8 | Shared low lane, input value |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Byte captured on the last read or fetch |
| done | output | 1 | One-tick completion pulse at end of T4 |

## Verification
The whole cycle is decoded from the phase and state counters. A wrong phase or state value therefore shows at the ports on the same tick: a strobe edge moves by one tick, or the lane enable overlaps the read strobe. A wrong latched cycle kind shows as the wrong strobe from tick 1 or 2. A bad capture point shows in `rdata` from tick 9. A counter that fails to wrap shows as a missing or extra `done` by tick 11. Because every tick of every cycle is compared against a computed timeline, any such fault is caught within one bus cycle.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int TPS = 3,
  parameter int NST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          done
);
  localparam int PW = $clog2(TPS);
  localparam int SW = $clog2(NST);
  localparam int KW = $clog2(TPS*NST);
  localparam logic [KW-1:0] K_ADR_END = KW'(TPS-2);
  localparam logic [KW-1:0] K_RD0     = KW'(TPS-1);
  localparam logic [KW-1:0] K_RD1     = KW'(3*TPS-1);
  localparam logic [KW-1:0] K_WR0     = KW'(TPS/2);
  localparam logic [KW-1:0] K_WR1     = KW'(2*TPS-1);
  localparam logic [KW-1:0] K_LAST    = KW'(TPS*NST-1);

  logic          busy;
  logic [PW-1:0] ph;
  logic [SW-1:0] ts;
  logic [AW-1:0] a_q;
  logic [DW-1:0] w_q;
  logic          wr_q;
  logic [KW-1:0] k;

  assign k = KW'(ts) * KW'(TPS) + KW'(ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ph    <= '0;
      ts    <= '0;
      a_q   <= '0;
      w_q   <= '0;
      wr_q  <= 1'b0;
      rdata <= '0;
    end else if (!busy) begin
      if (req) begin
        busy <= 1'b1;
        ph   <= '0;
        ts   <= '0;
        a_q  <= addr;
        w_q  <= wdata;
        wr_q <= (op == 2'b10);
      end
    end else begin
      if (ph == PW'(TPS-1)) begin
        ph <= '0;
        if (ts == SW'(NST-1)) busy <= 1'b0;
        else ts <= ts + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
      if (!wr_q && k == K_RD1) rdata <= ad_in;
    end
  end

  assign ale     = busy && (k == '0);
  assign rd_n    = !(busy && !wr_q && k >= K_RD0 && k <= K_RD1);
  assign wr_n    = !(busy &&  wr_q && k >= K_WR0 && k <= K_WR1);
  assign ad_oe   = busy && (wr_q ? (k <= K_RD1) : (k <= K_ADR_END));
  assign ad_out  = !ad_oe ? '0 : (wr_q && k >= K_WR0) ? w_q : a_q[DW-1:0];
  assign addr_hi = busy ? a_q[AW-1:DW] : '0;
  assign done    = busy && (k == K_LAST);

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          ad_oe,
  input logic          done,
  input logic [DW-1:0] rdata
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> wr_n);
  // R5
  rd_lane_free_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe);
  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  // R3
  ale_sep_chk: assert property (@(posedge clk) disable iff (rst) ale |-> (rd_n && wr_n && ad_oe));
  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> (!done && !busy));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n && !ale && !ad_oe && !done));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(rdata));
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .done(done), .rdata(rdata)
);

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  addr_hi, ad_out, rdata;
  logic        ad_oe, ale, rd_n, wr_n, done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [7:0] exp_rdata = '0;

  always #5 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst(rst), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .done(done)
  );

  task automatic chk(input string r, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic bit is_wr(input logic [1:0] o); return o == 2'b10; endfunction
  function automatic logic e_ale(input int k); return k == 0; endfunction
  function automatic logic e_rd_n(input logic [1:0] o, input int k);
    return !(!is_wr(o) && k >= 2 && k <= 8);
  endfunction
  function automatic logic e_wr_n(input logic [1:0] o, input int k);
    return !(is_wr(o) && k >= 1 && k <= 5);
  endfunction
  function automatic logic e_oe(input logic [1:0] o, input int k);
    return is_wr(o) ? (k <= 8) : (k <= 1);
  endfunction
  function automatic logic [7:0] e_ad(input logic [1:0] o, input int k, input logic [15:0] a, input logic [7:0] w);
    if (!e_oe(o, k)) return 8'h00;
    if (is_wr(o) && k >= 1) return w;
    return a[7:0];
  endfunction

  task automatic check_idle(input string tag);
    chk("R9", {tag, " rd_n"}, 16'(rd_n), 16'h1);
    chk("R9", {tag, " wr_n"}, 16'(wr_n), 16'h1);
    chk("R9", {tag, " ale"}, 16'(ale), 16'h0);
    chk("R9", {tag, " ad_oe"}, 16'(ad_oe), 16'h0);
    chk("R1", {tag, " done"}, 16'(done), 16'h0);
    chk("R2", {tag, " addr_hi"}, 16'(addr_hi), 16'h0);
    chk("R9", {tag, " rdata"}, 16'(rdata), 16'(exp_rdata));
  endtask

  // called at a negedge while idle; returns at the negedge after tick 11
  task automatic xact(input logic [1:0] o, input logic [15:0] a, input logic [7:0] w,
                      input logic [7:0] din, input bit noise);
    req = 1'b1; op = o; addr = a; wdata = w; ad_in = din;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 12; k++) begin
      string rr;
      chk("R2", "addr_hi", 16'(addr_hi), 16'(a[15:8]));
      chk("R3", "ale", 16'(ale), 16'(e_ale(k)));
      rr = is_wr(o) ? "R8" : "R4";
      chk(rr, "ad_oe", 16'(ad_oe), 16'(e_oe(o, k)));
      chk(rr, "ad_out", 16'(ad_out), 16'(e_ad(o, k, a, w)));
      chk(is_wr(o) ? "R7" : "R5", "rd_n", 16'(rd_n), 16'(e_rd_n(o, k)));
      chk(is_wr(o) ? "R7" : "R5", "wr_n", 16'(wr_n), 16'(e_wr_n(o, k)));
      chk("R1", "done", 16'(done), 16'(k == 11));
      if (k == 9 && !is_wr(o)) exp_rdata = din;
      chk("R6", "rdata", 16'(rdata), 16'(exp_rdata));
      if (noise && k >= 3 && k <= 5) begin
        // R10: requests during a cycle must be ignored
        req = 1'b1; op = 2'($urandom_range(0, 3)); addr = 16'($urandom);
        wdata = 8'($urandom);
      end
      if (k == 6) req = 1'b0;
      if (k == 9) ad_in = 8'($urandom);
      @(negedge clk);
    end
    check_idle("post-cycle");
  endtask

  initial begin
    #(1_000_000);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("reset");  // R11
    // R10: req low while idle keeps it idle; ad_in change ignored (R9)
    ad_in = 8'hA5;
    @(negedge clk);
    check_idle("idle");
    xact(2'b00, 16'h12F0, 8'h00, 8'h3C, 1'b0);   // R6 fetch
    xact(2'b01, 16'hFFFF, 8'h00, 8'hC3, 1'b1);   // R5 read + R10 noise
    xact(2'b10, 16'h0001, 8'h5A, 8'hEE, 1'b1);   // R7 R8 write, rdata kept (R9)
    xact(2'b11, 16'h8000, 8'h00, 8'h00, 1'b0);   // R6 op 11 as read
    xact(2'b10, 16'hABCD, 8'hFF, 8'h11, 1'b0);
    for (int i = 0; i < 60; i++)
      xact(2'($urandom_range(0, 3)), 16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    // R11: reset in the middle of a cycle
    xact(2'b01, 16'h4242, 8'h00, 8'h99, 1'b0);
    req = 1'b1; op = 2'b10; addr = 16'h7777; wdata = 8'h66;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_rdata = 8'h00;
    chk("R11", "rd_n after reset", 16'(rd_n), 16'h1);
    chk("R11", "wr_n after reset", 16'(wr_n), 16'h1);
    chk("R11", "ad_oe after reset", 16'(ad_oe), 16'h0);
    chk("R11", "ale after reset", 16'(ale), 16'h0);
    chk("R11", "rdata after reset", 16'(rdata), 16'h0);
    @(negedge clk);
    check_idle("after reset");
    xact(2'b00, 16'h0F0F, 8'h00, 8'h81, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule